// File: doc/BRIEF.md
# Latching Parity Bus Transceiver

The block joins two 9-bit ports, called A and B. Each port carries 8 data bits in bits 7:0 and one parity bit in bit 8. Each direction, A-to-B and B-to-A, has a storage stage with its own enable and its own active-low output enable. A common select chooses how the destination parity bit is formed. In one setting it is regenerated from the 8 stored data bits. In the other it is copied from the stored received parity bit. A common sense input chooses odd or even parity for both generation and checking.

Each port has an active-low parity flag that checks the word seen on that port. When the block is not driving the port, that word is the stored received word. When the block drives the port, it is the driven word, so the check covers the loop-back path. The tri-state pads lie outside the block: each port is split into an input vector, an output vector and an output enable.

By default the storage stage acts as a transparent latch. While its enable is high it passes the live input, and a register behind it keeps the last value for the time the enable is low. The parameter `USE_FLOPS` = 1 changes the stage to a plain clocked register for targets without latches. The stored word then reaches the outputs one clock later.

Top module: `parity_xcvr`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clk edge) clears both stored words to all-zero. This reset takes priority over the storage enables.
- R2: While a storage enable is high, the stage for that direction captures its port input at every rising clk edge. With USE_FLOPS=0 the stage also passes the live input straight through in the same cycle.
- R3: While a storage enable is low, the stored word of that direction does not change, and the outputs fed from it hold their values.
- R4: a_oe is the inverse of oe_ba_n and b_oe is the inverse of oe_ab_n. A port output that is not enabled reads as all-zero.
- R5: With par_pass = 0 (generate mode), the driven bit 8 equals the XOR of the stored data bits 7:0, XORed with odd_sel. odd_sel = 1 selects odd parity and odd_sel = 0 selects even parity.
- R6: With par_pass = 1 (feed-through mode), the driven bit 8 equals bit 8 of the stored source word.
- R7: Driven bits 7:0 equal bits 7:0 of the stored word of the opposite port: a_in feeds b_out and b_in feeds a_out.
- R8: For a port the block is not driving, its flag (a_perr_n or b_perr_n) is high exactly when the XOR of all 9 bits of that port's stored word equals odd_sel. The flag is low on a mismatch.
- R9: For a port the block is driving, its flag applies the check of R8 to the 9-bit word being driven onto that port. In generate mode this flag is therefore always high.
- R10: With USE_FLOPS=1 the outputs come only from the stored words. An input therefore shows at the opposite port one clock after a rising edge at which its enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| odd_sel | input | 1 | Parity sense: 1 odd, 0 even |
| par_pass | input | 1 | 1 feed-through of received parity, 0 regenerate |
| le_ab | input | 1 | Storage enable, A-to-B direction |
| le_ba | input | 1 | Storage enable, B-to-A direction |
| oe_ab_n | input | 1 | Active-low output enable onto the B port |
| oe_ba_n | input | 1 | Active-low output enable onto the A port |
| a_in | input | 9 | A port receive word (bit 8 parity) |
| a_out | output | 9 | A port drive word |
| a_oe | output | 1 | A port pad enable |
| a_perr_n | output | 1 | A side parity flag, low on mismatch |
| b_in | input | 9 | B port receive word (bit 8 parity) |
| b_out | output | 9 | B port drive word |
| b_oe | output | 1 | B port pad enable |
| b_perr_n | output | 1 | B side parity flag, low on mismatch |

## Verification
The bench steps through all 64 combinations of the two output enables, the parity select, the two storage enables and the parity sense. For each combination it drives random words with random parity bits. The closed-enable cycles catch a design that leaks live data past a closed stage. The both-enabled cases catch a flag that checks the received word instead of the driven word. The feed-through cases with bad parity catch a design that regenerates the parity bit when it should pass it through. A second instance built with registered storage is held to the one-cycle delay, and a reset with the storage enables high catches a reset that loses priority.

// File: rtl/pxc_pkg.sv
// Shared types for the parity transceiver.
package pxc_pkg;
    // How the destination parity bit is formed.
    typedef enum logic {
        PM_GEN  = 1'b0,
        PM_PASS = 1'b1
    } par_mode_e;
endpackage

// File: rtl/pxc_store.sv
// Storage stage for one direction.
// Assumes: synchronous active-low reset; le is sampled at rising clk.
// With USE_FLOPS=0 it behaves as a transparent latch: the live input
// passes through while le is high, and the held copy is used while le is low.
// With USE_FLOPS=1 q is the held copy alone.
module pxc_store #(
    parameter int unsigned WORD_W    = 9,
    parameter bit          USE_FLOPS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] held;

    // Capture the port word while enabled; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)  held <= '0;
        else if (le) held <= d;
    end

    generate
        if (USE_FLOPS) begin : g_flop
            // Registered view only.
            always_comb q = held;
        end else begin : g_latch
            // Transparent view while enabled.
            always_comb q = le ? d : held;
        end
    endgenerate

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(held));
    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (held == $past(d)));
endmodule

// File: rtl/pxc_drive.sv
// Drive path for one direction: forms the destination word from the
// stored source word. Assumes the parity bit is the top bit of the word.
module pxc_drive #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned WORD_W = DATA_W + 1
) (
    input  logic               [WORD_W-1:0] src,
    input  pxc_pkg::par_mode_e              mode,
    input  logic                            odd_sel,
    input  logic                            en,
    output logic               [WORD_W-1:0] out,
    output logic                            oe
);
    logic gen_par;

    // Parity that makes the word match the selected sense.
    always_comb gen_par = (^src[DATA_W-1:0]) ^ odd_sel;

    // Choose generated or received parity, gate with the enable.
    always_comb begin
        out = '0;
        if (en) begin
            out[DATA_W-1:0] = src[DATA_W-1:0];
            out[DATA_W]     = (mode == pxc_pkg::PM_PASS) ? src[DATA_W] : gen_par;
        end
    end

    // Pad enable follows the direction enable.
    always_comb oe = en;
endmodule

// File: rtl/pxc_check.sv
// Parity checker for one port: the flag is high when the 9-bit word
// agrees with the selected sense and low on a mismatch.
module pxc_check #(
    parameter int unsigned WORD_W = 9
) (
    input  logic [WORD_W-1:0] word,
    input  logic              odd_sel,
    output logic              ok_n
);
    // Compare the word's overall parity with the sense.
    always_comb ok_n = ((^word) == odd_sel);
endmodule

// File: rtl/parity_xcvr.sv
// Bidirectional 9-bit transceiver with per-direction storage, parity
// regenerate or feed-through, and a parity flag per port.
// Assumes: tri-state pads outside; ports split into in/out/oe.
// Index 0 is the A side (A-to-B direction), index 1 is the B side.
module parity_xcvr #(
    parameter int unsigned DATA_W    = 8,
    parameter bit          USE_FLOPS = 1'b0,
    localparam int unsigned WORD_W   = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odd_sel,
    input  logic              par_pass,
    input  logic              le_ab,
    input  logic              le_ba,
    input  logic              oe_ab_n,
    input  logic              oe_ba_n,
    input  logic [WORD_W-1:0] a_in,
    output logic [WORD_W-1:0] a_out,
    output logic              a_oe,
    output logic              a_perr_n,
    input  logic [WORD_W-1:0] b_in,
    output logic [WORD_W-1:0] b_out,
    output logic              b_oe,
    output logic              b_perr_n
);
    localparam int unsigned NSIDE = 2;

    logic [WORD_W-1:0] rx   [NSIDE];
    logic [WORD_W-1:0] lat  [NSIDE];
    logic [WORD_W-1:0] drv  [NSIDE];
    logic [WORD_W-1:0] seen [NSIDE];
    logic              le   [NSIDE];
    logic              en   [NSIDE];
    logic              oe   [NSIDE];
    logic              ok_n [NSIDE];
    pxc_pkg::par_mode_e mode;

    // Gather the per-side inputs into arrays.
    always_comb begin
        rx[0] = a_in;   rx[1] = b_in;
        le[0] = le_ab;  le[1] = le_ba;
        en[0] = !oe_ab_n;
        en[1] = !oe_ba_n;
        mode  = pxc_pkg::par_mode_e'(par_pass);
    end

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            // Storage for words received on side s.
            pxc_store #(.WORD_W(WORD_W), .USE_FLOPS(USE_FLOPS)) u_store (
                .clk(clk), .rst_n(rst_n), .le(le[s]), .d(rx[s]), .q(lat[s])
            );
            // Drive path from side s onto the other side.
            pxc_drive #(.DATA_W(DATA_W)) u_drive (
                .src(lat[s]), .mode(mode), .odd_sel(odd_sel),
                .en(en[s]), .out(drv[s]), .oe(oe[s])
            );
            // Word on side s: driven word if the block drives it.
            always_comb seen[s] = en[NSIDE-1-s] ? drv[NSIDE-1-s] : lat[s];
            // Flag for side s.
            pxc_check #(.WORD_W(WORD_W)) u_check (
                .word(seen[s]), .odd_sel(odd_sel), .ok_n(ok_n[s])
            );

            // R9
            gen_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!par_pass && en[s]) |-> ok_n[NSIDE-1-s]);
            // R3
            data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !le[s] && $past(!le[s]) && en[s] && $past(en[s]))
                |-> $stable(drv[s][DATA_W-1:0]));
        end
    endgenerate

    // Map arrays back onto the ports.
    always_comb begin
        b_out    = drv[0];
        b_oe     = oe[0];
        a_out    = drv[1];
        a_oe     = oe[1];
        a_perr_n = ok_n[0];
        b_perr_n = ok_n[1];
    end
endmodule

// File: tb/tb_parity_xcvr.sv
`timescale 1ns/100ps
module tb_parity_xcvr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic odd_sel = 1'b0, par_pass = 1'b0, le_ab = 1'b0, le_ba = 1'b0;
    logic oe_ab_n = 1'b1, oe_ba_n = 1'b1;
    logic [8:0] a_in = '0, b_in = '0;
    logic [8:0] a_out, b_out, ra_out, rb_out;
    logic a_oe, b_oe, a_perr_n, b_perr_n;
    logic ra_oe, rb_oe, ra_perr_n, rb_perr_n;

    int total = 0;
    int fails = 0;
    logic [8:0] ha = '0, hb = '0;   // reference stored words

    always #2.5 clk = ~clk;

    parity_xcvr #(.DATA_W(8), .USE_FLOPS(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .par_pass(par_pass),
        .le_ab(le_ab), .le_ba(le_ba), .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .a_perr_n(a_perr_n),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .b_perr_n(b_perr_n));

    parity_xcvr #(.DATA_W(8), .USE_FLOPS(1'b1)) dut_reg (
        .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .par_pass(par_pass),
        .le_ab(le_ab), .le_ba(le_ba), .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
        .a_in(a_in), .a_out(ra_out), .a_oe(ra_oe), .a_perr_n(ra_perr_n),
        .b_in(b_in), .b_out(rb_out), .b_oe(rb_oe), .b_perr_n(rb_perr_n));

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected driven word from a stored source word (R5, R6, R7).
    function automatic logic [8:0] form(input logic [8:0] src);
        logic p;
        p = par_pass ? src[8] : ((^src[7:0]) ^ odd_sel);
        return {p, src[7:0]};
    endfunction

    // Flag rule of R8/R9.
    function automatic logic flag(input logic [8:0] w);
        return ((^w) == odd_sel);
    endfunction

    // Compare one instance against the reference.
    task automatic compare(input bit regd,
                           input logic [8:0] ao, input logic ae, input logic ap,
                           input logic [8:0] bo, input logic be, input logic bp);
        logic [8:0] sa, sb, ea, eb;
        string pt, ft;
        sa = (regd || !le_ab) ? ha : a_in;
        sb = (regd || !le_ba) ? hb : b_in;
        eb = oe_ab_n ? 9'h0 : form(sa);
        ea = oe_ba_n ? 9'h0 : form(sb);
        pt = par_pass ? "R6" : "R5";
        chk(regd ? "R10 R7 b data" : (le_ab ? "R2 R7 b data" : "R3 R7 b data"),
            {1'b0, bo[7:0]}, {1'b0, eb[7:0]});
        chk(regd ? "R10 a data" : (le_ba ? "R2 R7 a data" : "R3 R7 a data"),
            {1'b0, ao[7:0]}, {1'b0, ea[7:0]});
        chk(oe_ab_n ? "R4 b par" : {pt, " b par"}, {8'h0, bo[8]}, {8'h0, eb[8]});
        chk(oe_ba_n ? "R4 a par" : {pt, " a par"}, {8'h0, ao[8]}, {8'h0, ea[8]});
        chk("R4 oe", {7'h0, ae, be}, {7'h0, !oe_ba_n, !oe_ab_n});
        ft = oe_ba_n ? "R8 a flag" : "R9 a flag";
        chk(ft, {8'h0, ap}, {8'h0, flag(oe_ba_n ? sa : ea)});
        ft = oe_ab_n ? "R8 b flag" : "R9 b flag";
        chk(ft, {8'h0, bp}, {8'h0, flag(oe_ab_n ? sb : eb)});
    endtask

    // One cycle: inputs are already set after a falling edge; check, then clock.
    task automatic cycle();
        #1;
        if (rst_n) begin
            compare(1'b0, a_out, a_oe, a_perr_n, b_out, b_oe, b_perr_n);
            compare(1'b1, ra_out, ra_oe, ra_perr_n, rb_out, rb_oe, rb_perr_n);
        end
        @(posedge clk);
        if (!rst_n) begin ha = '0; hb = '0; end
        else begin
            if (le_ab) ha = a_in;
            if (le_ba) hb = b_in;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        // Reset with enables high: reset must win (R1).
        rst_n = 1'b0; le_ab = 1'b1; le_ba = 1'b1;
        a_in = 9'h1a5; b_in = 9'h0c3;
        cycle(); cycle();
        rst_n = 1'b1; le_ab = 1'b0; le_ba = 1'b0;
        oe_ab_n = 1'b0; oe_ba_n = 1'b0; par_pass = 1'b1; odd_sel = 1'b0;
        #1;
        chk("R1 b_out after reset", b_out, 9'h000);
        chk("R1 a_out after reset", a_out, 9'h000);
        chk("R1 b_out after reset reg", rb_out, 9'h000);
        chk("R1 a_out after reset reg", ra_out, 9'h000);
        cycle();
        // Sweep every control combination over random words.
        for (int c = 0; c < 64; c++) begin
            for (int r = 0; r < 6; r++) begin
                {oe_ab_n, oe_ba_n, par_pass, le_ab, le_ba, odd_sel} = 6'(c);
                a_in = 9'($urandom);
                b_in = 9'($urandom);
                cycle();
            end
        end
        // Closed stage with changing input, outputs must hold (R3).
        oe_ab_n = 1'b0; oe_ba_n = 1'b1; par_pass = 1'b1; le_ab = 1'b1;
        a_in = 9'h155; cycle();
        le_ab = 1'b0;
        for (int r = 0; r < 4; r++) begin a_in = 9'($urandom); cycle(); end
        chk("R3 b_out hold", b_out, 9'h155);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule